// File: doc/BRIEF.md
# AUX Request Staging Engine

This block sits between a host-side byte register port and a DisplayPort AUX link engine. The host stages one AUX request by writing the target address and command, the encoded length and, for writes, the payload bytes. Writing the start bit hands the request to the link engine over a valid/ready handshake, streams the payload out, then waits for a reply. The reply code and the byte count are packed into a status byte, and any read bytes returned by the link are queued for the host to pop.

The host port is an 8-bit read/write window: reads of ordinary registers are combinational, and reads of the receive window pop one byte on the clock edge. A configuration write clears both queues, the status byte and any transaction in flight. A programmable cycle limit ends a transaction that gets no reply.

Top module: `aux_stage`

## Requirements
- R1: Offsets 0x7D, 0x7E and 0x7F hold address bits 7:0, 15:8 and 19:16 (0x7F low nibble); the 0x7F high nibble is the 4-bit command, where command bit 0 set means a read. All three read back and drive `reqAddr`/`reqCmd`.
- R2: Offset 0x80 holds the length: if bit 7 is set, `reqLen` is 0; otherwise `reqLen` is bits 3:0 plus one (1 to 16).
- R3: Writing 1 in bit 0 of 0x83 while idle starts a transaction. Bit 0 of 0x83 reads 1 until the transaction ends, then 0. `reqValid` holds until `reqReady`.
- R4: Bytes written to 0x81 are queued and, for a write command, exactly `reqLen` of them are presented on `txData` in write order, one per `txValid && txReady` cycle.
- R5: Bytes arriving on `rxData` with `rxValid` before the reply are queued. Each read of 0x82 returns and removes the oldest one. A read of an empty queue returns 0x00 and changes nothing.
- R6: On `rspValid`, offset 0x84 becomes `{rspCode[2:0], rspCount[4:0]}` (codes 1 NACK, 2 DEFER, 3 ACK, 4 invalid, 5 I2C NACK, 6 I2C DEFER) and the transaction ends.
- R7: With no reply within `TIMEOUT_CYCLES` busy cycles, the transaction ends with status 0xE0 (code 7, count 0).
- R8: While busy, host writes to 0x7D–0x81 are ignored.
- R9: Writing 0xFF to 0x76 empties both queues, zeroes the status and returns the block to idle. Staged address and length remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWe | input | 1 | Host write strobe |
| hostRe | input | 1 | Host read strobe (pops at 0x82) |
| hostAddr | input | 8 | Host register offset |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data (combinational) |
| reqValid | output | 1 | Request offered to link engine |
| reqReady | input | 1 | Link engine accepts request |
| reqCmd | output | 4 | AUX command nibble |
| reqAddr | output | 20 | AUX address |
| reqLen | output | 5 | Decoded byte length (0–16) |
| txValid | output | 1 | Payload byte valid |
| txReady | input | 1 | Link engine takes payload byte |
| txData | output | 8 | Payload byte |
| rxValid | input | 1 | Returned read byte valid |
| rxData | input | 8 | Returned read byte |
| rspValid | input | 1 | Reply strobe |
| rspCode | input | 3 | Reply code |
| rspCount | input | 5 | Bytes moved |

## Verification
The hardest case to reach is a host write that arrives during a live transaction. The bench starts a read and holds `reqReady` low, so the request stays parked. It then writes new address, length and payload values, checks that the link-side fields and readback have not moved, and completes the request. The next write transaction shows that the write issued during the busy period never entered the payload queue. The timeout is reached by starting a request and never answering it.

// File: rtl/aux_stage_pkg.sv
package aux_stage_pkg;
  localparam logic [7:0] OFF_CFG   = 8'h76;
  localparam logic [7:0] OFF_ADDR0 = 8'h7D;
  localparam logic [7:0] OFF_ADDR1 = 8'h7E;
  localparam logic [7:0] OFF_ADDR2 = 8'h7F;
  localparam logic [7:0] OFF_LEN   = 8'h80;
  localparam logic [7:0] OFF_WDATA = 8'h81;
  localparam logic [7:0] OFF_RDATA = 8'h82;
  localparam logic [7:0] OFF_CTRL  = 8'h83;
  localparam logic [7:0] OFF_STAT  = 8'h84;
  localparam logic [7:0] CFG_CLEAR_VAL = 8'hFF;
  localparam logic [2:0] CODE_TIMEOUT  = 3'd7;

  typedef struct packed {
    logic       txPop;
    logic       rxAccept;
    logic       statusLoad;
    logic [2:0] statusCode;
    logic [4:0] statusCount;
  } ctl_strobe_t;
endpackage

// File: rtl/aux_stage_fifo.sv
module aux_stage_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0;
    end else if (clr) begin
      wrPtr <= '0; rdPtr <= '0; count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clr) |=> full);
  // R5
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/aux_stage_dp.sv
module aux_stage_dp
  import aux_stage_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic        hostRe,
  input  logic [7:0]  hostAddr,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  input  logic        busy,
  input  ctl_strobe_t strb,
  output logic [3:0]  reqCmd,
  output logic [19:0] reqAddr,
  output logic [4:0]  reqLen,
  output logic [7:0]  txData,
  input  logic [7:0]  rxData
);
  logic [7:0] addrLo, addrMid, addrHi, lenReg, statusReg;
  logic cfgClear, wrPush, rdPop;
  logic [7:0] rxHead;
  logic txEmpty, txFull, rxEmpty, rxFull;

  assign cfgClear = hostWe && hostAddr == OFF_CFG && hostWdata == CFG_CLEAR_VAL;
  assign wrPush   = hostWe && hostAddr == OFF_WDATA && !busy;
  assign rdPop    = hostRe && hostAddr == OFF_RDATA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLo <= '0; addrMid <= '0; addrHi <= '0; lenReg <= '0;
    end else if (hostWe && !busy) begin
      case (hostAddr)
        OFF_ADDR0: addrLo  <= hostWdata;
        OFF_ADDR1: addrMid <= hostWdata;
        OFF_ADDR2: addrHi  <= hostWdata;
        OFF_LEN:   lenReg  <= hostWdata & 8'h8F;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                statusReg <= '0;
    else if (cfgClear)        statusReg <= '0;
    else if (strb.statusLoad) statusReg <= {strb.statusCode, strb.statusCount};
  end

  assign reqCmd  = addrHi[7:4];
  assign reqAddr = {addrHi[3:0], addrMid, addrLo};
  assign reqLen  = lenReg[7] ? 5'd0 : {1'b0, lenReg[3:0]} + 5'd1;

  aux_stage_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) txFifo_i (
    .clk, .rstN, .clr(cfgClear), .push(wrPush), .pushData(hostWdata),
    .pop(strb.txPop), .popData(txData), .empty(txEmpty), .full(txFull));

  aux_stage_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rxFifo_i (
    .clk, .rstN, .clr(cfgClear), .push(strb.rxAccept), .pushData(rxData),
    .pop(rdPop), .popData(rxHead), .empty(rxEmpty), .full(rxFull));

  always_comb begin
    case (hostAddr)
      OFF_ADDR0: hostRdata = addrLo;
      OFF_ADDR1: hostRdata = addrMid;
      OFF_ADDR2: hostRdata = addrHi;
      OFF_LEN:   hostRdata = lenReg;
      OFF_RDATA: hostRdata = rxHead;
      OFF_CTRL:  hostRdata = {7'd0, busy};
      OFF_STAT:  hostRdata = statusReg;
      default:   hostRdata = 8'h00;
    endcase
  end

  // R8
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({addrLo, addrMid, addrHi, lenReg}));
  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.statusLoad && !cfgClear) |=> $stable(statusReg));
endmodule

// File: rtl/aux_stage_ctl.sv
module aux_stage_ctl
  import aux_stage_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [7:0]  hostAddr,
  input  logic [7:0]  hostWdata,
  input  logic [3:0]  reqCmd,
  input  logic [4:0]  reqLen,
  output logic        reqValid,
  input  logic        reqReady,
  output logic        txValid,
  input  logic        txReady,
  input  logic        rxValid,
  input  logic        rspValid,
  input  logic [2:0]  rspCode,
  input  logic [4:0]  rspCount,
  output logic        busy,
  output ctl_strobe_t strb
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_SEND, S_WAIT} state_t;
  state_t state;
  logic [TW-1:0] timer;
  logic [4:0] remaining;
  logic startReq, clearReq, timeoutHit, replyNow;

  assign clearReq   = hostWe && hostAddr == OFF_CFG && hostWdata == CFG_CLEAR_VAL;
  assign startReq   = hostWe && hostAddr == OFF_CTRL && hostWdata[0] && state == S_IDLE;
  assign busy       = (state != S_IDLE);
  assign reqValid   = (state == S_REQ);
  assign txValid    = (state == S_SEND);
  assign replyNow   = (state == S_WAIT) && rspValid;
  assign timeoutHit = busy && !replyNow && timer == TW'(TIMEOUT_CYCLES - 1);

  always_comb begin
    strb = '0;
    strb.txPop    = txValid && txReady;
    strb.rxAccept = (state == S_WAIT) && rxValid;
    if (replyNow) begin
      strb.statusLoad  = 1'b1;
      strb.statusCode  = rspCode;
      strb.statusCount = rspCount;
    end else if (timeoutHit) begin
      strb.statusLoad = 1'b1;
      strb.statusCode = CODE_TIMEOUT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; timer <= '0; remaining <= '0;
    end else if (clearReq) begin
      state <= S_IDLE; timer <= '0; remaining <= '0;
    end else if (state == S_IDLE) begin
      timer <= '0;
      if (startReq) state <= S_REQ;
    end else begin
      timer <= timer + 1'b1;
      if (timeoutHit) state <= S_IDLE;
      else begin
        case (state)
          S_REQ: if (reqReady) begin
            remaining <= reqLen;
            state <= (!reqCmd[0] && reqLen != 5'd0) ? S_SEND : S_WAIT;
          end
          S_SEND: if (txReady) begin
            remaining <= remaining - 5'd1;
            if (remaining == 5'd1) state <= S_WAIT;
          end
          S_WAIT: if (rspValid) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && !clearReq && !timeoutHit) |=> reqValid);
  // R7
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (timer < TW'(TIMEOUT_CYCLES)));
  // R4
  tx_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (remaining != 5'd0));
endmodule

// File: rtl/aux_stage.sv
module aux_stage
  import aux_stage_pkg::*;
#(
  parameter int FIFO_DEPTH     = 16,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic        hostRe,
  input  logic [7:0]  hostAddr,
  input  logic [7:0]  hostWdata,
  output logic [7:0]  hostRdata,
  output logic        reqValid,
  input  logic        reqReady,
  output logic [3:0]  reqCmd,
  output logic [19:0] reqAddr,
  output logic [4:0]  reqLen,
  output logic        txValid,
  input  logic        txReady,
  output logic [7:0]  txData,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        rspValid,
  input  logic [2:0]  rspCode,
  input  logic [4:0]  rspCount
);
  ctl_strobe_t strb;
  logic busy;

  aux_stage_ctl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctl_i (
    .clk, .rstN, .hostWe, .hostAddr, .hostWdata, .reqCmd, .reqLen,
    .reqValid, .reqReady, .txValid, .txReady, .rxValid, .rspValid,
    .rspCode, .rspCount, .busy, .strb);

  aux_stage_dp #(.FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk, .rstN, .hostWe, .hostRe, .hostAddr, .hostWdata, .hostRdata,
    .busy, .strb, .reqCmd, .reqAddr, .reqLen, .txData, .rxData);
endmodule

// File: tb/aux_stage_tb_top.sv
module aux_stage_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;

  logic clk = 0, rstN = 0;
  logic hostWe = 0, hostRe = 0;
  logic [7:0] hostAddr = 0, hostWdata = 0, hostRdata;
  logic reqValid, reqReady = 0, txValid, txReady = 0, rxValid = 0, rspValid = 0;
  logic [3:0] reqCmd;
  logic [19:0] reqAddr;
  logic [4:0] reqLen, rspCount = 0;
  logic [7:0] txData, rxData = 0;
  logic [2:0] rspCode = 0;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_stage #(.FIFO_DEPTH(16), .TIMEOUT_CYCLES(TMO)) dut_i (.*);

  // {cmd[4], addr[20], lenByte[8], code[3], count[5], seed[8]}
  localparam logic [47:0] VEC [6] = '{
    {4'h8, 20'h12345, 8'h03, 3'd3, 5'd4,  8'h10},
    {4'h9, 20'hF0001, 8'h0F, 3'd3, 5'd16, 8'h20},
    {4'h1, 20'h00050, 8'h00, 3'd5, 5'd0,  8'h30},
    {4'h0, 20'h00050, 8'h80, 3'd3, 5'd0,  8'h40},
    {4'h9, 20'h00100, 8'h07, 3'd2, 5'd0,  8'h50},
    {4'h8, 20'h0ABCD, 8'h01, 3'd1, 5'd1,  8'h60}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); hostWe = 1; hostAddr = a; hostWdata = d;
    @(negedge clk); hostWe = 0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); hostRe = 1; hostAddr = a; #1 d = hostRdata;
    @(negedge clk); hostRe = 0;
  endtask

  task automatic stage(input logic [3:0] c, input logic [19:0] ad, input logic [7:0] ln);
    hostWrite(8'h7D, ad[7:0]);
    hostWrite(8'h7E, ad[15:8]);
    hostWrite(8'h7F, {c, ad[19:16]});
    hostWrite(8'h80, ln);
  endtask

  task automatic serve(input logic [3:0] c, input logic [19:0] ad, input logic [4:0] ln,
                       input int nTx, input logic [7:0] seed, input int nRx,
                       input logic [2:0] code, input logic [4:0] cnt);
    int g = 0;
    while (!reqValid && g < 100) begin @(negedge clk); g++; end
    check(reqValid, "R3 reqValid", reqValid, 1);
    check(reqCmd == c, "R1 cmd", reqCmd, c);
    check(reqAddr == ad, "R1 addr", reqAddr, ad);
    check(reqLen == ln, "R2 len", reqLen, ln);
    reqReady = 1; @(negedge clk); reqReady = 0;
    txReady = 1;
    for (int i = 0; i < nTx; i++) begin
      g = 0;
      while (!txValid && g < 20) begin @(negedge clk); g++; end
      check(txValid && txData == 8'(seed + i*3), "R4 txData", txData, 8'(seed + i*3));
      @(negedge clk);
    end
    txReady = 0;
    check(!txValid, "R4 no extra tx", txValid, 0);
    for (int i = 0; i < nRx; i++) begin
      rxValid = 1; rxData = 8'(seed + 8'h80 + i); @(negedge clk);
    end
    rxValid = 0;
    rspValid = 1; rspCode = code; rspCount = cnt; @(negedge clk);
    rspValid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;
    hostRead(8'h84, rd); check(rd == 0, "R6 reset status", rd, 0);
    hostRead(8'h83, rd); check(rd == 0, "R3 reset idle", rd, 0);
    hostRead(8'h82, rd); check(rd == 0, "R5 reset empty pop", rd, 0);

    for (int v = 0; v < 6; v++) begin
      logic [3:0] c; logic [19:0] ad; logic [7:0] ln, seed;
      logic [2:0] code; logic [4:0] cnt, dl; int nTx, nRx;
      {c, ad, ln, code, cnt, seed} = VEC[v];
      dl = ln[7] ? 5'd0 : 5'(ln[3:0]) + 5'd1;
      nTx = c[0] ? 0 : int'(dl);
      nRx = c[0] ? int'(cnt) : 0;
      hostWrite(8'h76, 8'hFF);
      stage(c, ad, ln);
      hostRead(8'h7F, rd); check(rd == {c, ad[19:16]}, "R1 readback", rd, {c, ad[19:16]});
      for (int i = 0; i < nTx; i++) hostWrite(8'h81, 8'(seed + i*3));
      hostWrite(8'h83, 8'h01);
      hostRead(8'h83, rd); check(rd == 1, "R3 busy", rd, 1);
      serve(c, ad, dl, nTx, seed, nRx, code, cnt);
      hostRead(8'h83, rd); check(rd == 0, "R3 self clear", rd, 0);
      hostRead(8'h84, rd); check(rd == {code, cnt}, "R6 status", rd, {code, cnt});
      for (int i = 0; i < nRx; i++) begin
        hostRead(8'h82, rd);
        check(rd == 8'(seed + 8'h80 + i), "R5 rxData", rd, 8'(seed + 8'h80 + i));
      end
      hostRead(8'h82, rd); check(rd == 0, "R5 empty pop", rd, 0);
    end

    // R8: writes while busy are ignored
    hostWrite(8'h76, 8'hFF);
    stage(4'h9, 20'h00ABC, 8'h00);
    hostWrite(8'h83, 8'h01);
    hostWrite(8'h7D, 8'h55);
    hostWrite(8'h80, 8'h05);
    hostWrite(8'h81, 8'h77);
    check(reqAddr == 20'h00ABC, "R8 addr held", reqAddr, 20'h00ABC);
    check(reqLen == 5'd1, "R8 len held", reqLen, 1);
    hostRead(8'h7D, rd); check(rd == 8'hBC, "R8 readback held", rd, 8'hBC);
    serve(4'h9, 20'h00ABC, 5'd1, 0, 8'h00, 1, 3'd3, 5'd1);
    hostRead(8'h84, rd); check(rd == 8'h61, "R6 status", rd, 8'h61);
    hostRead(8'h82, rd); check(rd == 8'h80, "R5 rxData", rd, 8'h80);
    stage(4'h8, 20'h00ABC, 8'h00);
    hostWrite(8'h81, 8'h99);
    hostWrite(8'h83, 8'h01);
    serve(4'h8, 20'h00ABC, 5'd1, 1, 8'h99, 0, 3'd3, 5'd1);

    // R9: clear empties queues and status
    hostWrite(8'h81, 8'h11);
    hostWrite(8'h81, 8'h22);
    hostWrite(8'h76, 8'hFF);
    hostRead(8'h84, rd); check(rd == 0, "R9 status cleared", rd, 0);
    hostWrite(8'h81, 8'h33);
    hostWrite(8'h83, 8'h01);
    serve(4'h8, 20'h00ABC, 5'd1, 1, 8'h33, 0, 3'd3, 5'd1);
    stage(4'h9, 20'h00001, 8'h01);
    hostWrite(8'h83, 8'h01);
    serve(4'h9, 20'h00001, 5'd2, 0, 8'h00, 2, 3'd3, 5'd2);
    hostWrite(8'h76, 8'hFF);
    hostRead(8'h82, rd); check(rd == 0, "R9 rx queue cleared", rd, 0);

    // R7: no reply ends with timeout status
    stage(4'h9, 20'h00002, 8'h00);
    hostWrite(8'h83, 8'h01);
    repeat (TMO + 8) @(negedge clk);
    hostRead(8'h83, rd); check(rd == 0, "R7 idle after timeout", rd, 0);
    hostRead(8'h84, rd); check(rd == 8'hE0, "R7 timeout status", rd, 8'hE0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule